// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block takes one interrupt delivery request at a time, works out which processors it is meant for, and hands the interrupt to those processors one after another. A request carries an 8-bit destination byte, a destination-mode bit (physical or logical), a 3-bit delivery mode, a vector and a trigger-mode bit. The identity of every processor slot is supplied on input pins: whether the slot is populated, its physical ID, its logical ID and its current priority.

The resolver turns the destination into a target bitmask. The delivery mode then trims the mask. Fixed delivery keeps every target, lowest-priority delivery keeps a single one, and any other mode keeps none. The dispatcher then walks the mask from the lowest index upward and emits one beat per target.

The request side is a valid/ready input. `req_ready` is high only while nothing is waiting to be dispatched, so a request is taken only on a cycle where `req_valid` and `req_ready` are both high. The dispatch side is a valid/ready output. A beat is consumed on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the beat is held unchanged. The first beat appears on the cycle after the request is accepted.

Top module: `irq_dest_dispatch`

## Requirements
- R1: In physical mode (`req_logical`=0), a destination of 0xFF selects every present target.
- R2: In physical mode with any other destination, only the lowest-index present target whose physical ID equals the destination is selected.
- R3: In logical mode (`req_logical`=1), a destination of 0x00 selects no target.
- R4: In logical mode with a nonzero destination, every present target whose logical ID ANDed with the destination is nonzero is selected.
- R5: If the selection is empty, nothing is dispatched and `req_ready` stays high.
- R6: In fixed mode (`req_mode`=3'd0), each selected target gets exactly one beat. Beats come in ascending index order, one per handshake, and each carries the request's vector and trigger bit. `out_tgt` is one-hot.
- R7: In lowest-priority mode (`req_mode`=3'd1), exactly one beat is sent. It goes to the selected target with the smallest `tgt_prio`; on a tie, the lowest index wins.
- R8: For any `req_mode` other than 3'd0 or 3'd1, the request is accepted and dropped, and no beat is sent.
- R9: `busy` is high and `req_ready` is low while beats remain. A request offered during that time is ignored.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_tgt`, `out_vector` and `out_trig` hold steady.
- R11: After reset, `out_valid` and `busy` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_dest | input | ID_W | Destination byte |
| req_logical | input | 1 | 0 physical, 1 logical destination mode |
| req_mode | input | 3 | Delivery mode: 0 fixed, 1 lowest priority, others dropped |
| req_vector | input | VEC_W | Interrupt vector |
| req_trig | input | 1 | Trigger mode bit, passed through |
| tgt_present | input | N_TGT | Slot populated, one bit per target |
| tgt_phys_id | input | N_TGT*ID_W | Physical ID per target, target i at bits [i*ID_W +: ID_W] |
| tgt_log_id | input | N_TGT*ID_W | Logical ID per target, same packing |
| tgt_prio | input | N_TGT*PRIO_W | Priority per target, smaller wins |
| busy | output | 1 | Dispatch in progress |
| out_valid | output | 1 | Dispatch beat present |
| out_ready | input | 1 | Consumer accepts the beat |
| out_tgt | output | N_TGT | One-hot target of the beat |
| out_vector | output | VEC_W | Vector of the beat |
| out_trig | output | 1 | Trigger bit of the beat |

## Verification
The target table is fixed with deliberate overlaps. Two slots share a physical ID, one logical ID has two bits set, a populated-looking slot is marked absent, and two slots tie at the lowest priority.

Physical lookups on a duplicated ID, on an absent slot's ID and on broadcast show first-match behaviour apart from an OR of all matches, and show that absent slots are skipped. Logical lookups on zero, on a single bit and on a mix of bits show the zero rule apart from the AND-overlap rule. Lowest-priority requests over the tied pair, and unsupported modes, show the single-winner choice and the drop rule.

Back-pressure and a request offered mid-dispatch show that beats hold steady and that no request is lost or duplicated.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] DM_FIXED  = 3'd0;
  localparam logic [MODE_W-1:0] DM_LOWEST = 3'd1;
endpackage

// File: rtl/irq_dest_resolve.sv
module irq_dest_resolve #(
  parameter int N_TGT = 8,
  parameter int ID_W  = 8
) (
  input  logic [ID_W-1:0]       dest,
  input  logic                  logical,
  input  logic [N_TGT-1:0]      present,
  input  logic [N_TGT*ID_W-1:0] phys_id,
  input  logic [N_TGT*ID_W-1:0] log_id,
  output logic [N_TGT-1:0]      mask
);
  localparam logic [ID_W-1:0] BCAST = '1;

  logic [N_TGT-1:0] phys_mask;
  logic [N_TGT-1:0] log_mask;

  // physical: broadcast or first present match only
  always_comb begin
    logic found;
    found     = 1'b0;
    phys_mask = '0;
    if (dest == BCAST) begin
      phys_mask = present;
    end else begin
      for (int i = 0; i < N_TGT; i++) begin
        if (!found && present[i] && phys_id[i*ID_W +: ID_W] == dest) begin
          phys_mask[i] = 1'b1;
          found        = 1'b1;
        end
      end
    end
  end

  // logical: zero destination hits nobody, otherwise overlap test
  generate
    for (genvar g = 0; g < N_TGT; g++) begin : g_log
      assign log_mask[g] = present[g] && (dest != '0) &&
                           ((dest & log_id[g*ID_W +: ID_W]) != '0);
    end
  endgenerate

  assign mask = logical ? log_mask : phys_mask;

  always_comb begin
    if (!logical && dest != BCAST)
      AST_PHYS_FIRST_ONLY: assert ($onehot0(phys_mask)); // R2
    if (logical && dest == '0)
      AST_LOG_ZERO_NONE: assert (mask == '0); // R3
    AST_ONLY_PRESENT: assert ((mask & ~present) == '0); // R1
  end
endmodule

// File: rtl/irq_lowpri_pick.sv
module irq_lowpri_pick #(
  parameter int N_TGT  = 8,
  parameter int PRIO_W = 4
) (
  input  logic [N_TGT-1:0]        cand,
  input  logic [N_TGT*PRIO_W-1:0] prio,
  output logic [N_TGT-1:0]        winner
);
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1;

  always_comb begin
    logic              have;
    logic [PRIO_W-1:0] best;
    logic [IDX_W-1:0]  best_idx;
    have     = 1'b0;
    best     = '0;
    best_idx = '0;
    // strict less-than keeps the lower index on a tie
    for (int i = 0; i < N_TGT; i++) begin
      if (cand[i] && (!have || prio[i*PRIO_W +: PRIO_W] < best)) begin
        have     = 1'b1;
        best     = prio[i*PRIO_W +: PRIO_W];
        best_idx = IDX_W'(i);
      end
    end
    winner = '0;
    if (have) winner[best_idx] = 1'b1;
  end

  always_comb begin
    AST_LP_ONE_WINNER: assert ($onehot0(winner)); // R7
    AST_LP_FROM_CAND: assert ((winner & ~cand) == '0); // R7
    if (cand != '0)
      AST_LP_NONEMPTY: assert (winner != '0); // R7
  end
endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq #(
  parameter int N_TGT = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N_TGT-1:0] load_mask,
  input  logic [VEC_W-1:0] load_vector,
  input  logic             load_trig,
  output logic             idle,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N_TGT-1:0] out_tgt,
  output logic [VEC_W-1:0] out_vector,
  output logic             out_trig
);
  logic [N_TGT-1:0] pend_q;
  logic [VEC_W-1:0] vec_q;
  logic             trig_q;
  logic             fire;

  assign out_valid  = (pend_q != '0);
  assign idle       = !out_valid;
  assign out_tgt    = pend_q & (~pend_q + N_TGT'(1));
  assign out_vector = vec_q;
  assign out_trig   = trig_q;
  assign fire       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vec_q  <= '0;
      trig_q <= 1'b0;
    end else if (load) begin
      pend_q <= load_mask;
      vec_q  <= load_vector;
      trig_q <= load_trig;
    end else if (fire) begin
      pend_q <= pend_q & ~out_tgt;
    end
  end

  AST_BEAT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot(out_tgt)); // R6
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load) |=> (!out_valid || out_tgt > $past(out_tgt))); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tgt) &&
                                   $stable(out_vector) && $stable(out_trig))); // R10
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !load); // R9
endmodule

// File: rtl/irq_dest_dispatch.sv
module irq_dest_dispatch
  import irq_dest_pkg::*;
#(
  parameter int N_TGT  = 8,
  parameter int ID_W   = 8,
  parameter int VEC_W  = 8,
  parameter int PRIO_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ID_W-1:0]         req_dest,
  input  logic                    req_logical,
  input  logic [MODE_W-1:0]       req_mode,
  input  logic [VEC_W-1:0]        req_vector,
  input  logic                    req_trig,
  input  logic [N_TGT-1:0]        tgt_present,
  input  logic [N_TGT*ID_W-1:0]   tgt_phys_id,
  input  logic [N_TGT*ID_W-1:0]   tgt_log_id,
  input  logic [N_TGT*PRIO_W-1:0] tgt_prio,
  output logic                    busy,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [N_TGT-1:0]        out_tgt,
  output logic [VEC_W-1:0]        out_vector,
  output logic                    out_trig
);
  logic [N_TGT-1:0] cand;
  logic [N_TGT-1:0] lp_sel;
  logic [N_TGT-1:0] launch;
  logic             idle;
  logic             accept;

  irq_dest_resolve #(.N_TGT(N_TGT), .ID_W(ID_W)) u_resolve (
    .dest    (req_dest),
    .logical (req_logical),
    .present (tgt_present),
    .phys_id (tgt_phys_id),
    .log_id  (tgt_log_id),
    .mask    (cand)
  );

  irq_lowpri_pick #(.N_TGT(N_TGT), .PRIO_W(PRIO_W)) u_pick (
    .cand   (cand),
    .prio   (tgt_prio),
    .winner (lp_sel)
  );

  always_comb begin
    unique case (req_mode)
      DM_FIXED:  launch = cand;
      DM_LOWEST: launch = lp_sel;
      default:   launch = '0;
    endcase
  end

  assign accept    = req_valid && req_ready;
  assign req_ready = idle;
  assign busy      = !idle;

  irq_dispatch_seq #(.N_TGT(N_TGT), .VEC_W(VEC_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_mask   (launch),
    .load_vector (req_vector),
    .load_trig   (req_trig),
    .idle        (idle),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_tgt     (out_tgt),
    .out_vector  (out_vector),
    .out_trig    (out_trig)
  );

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R9
  AST_DROP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode != DM_FIXED && req_mode != DM_LOWEST) |=> !busy); // R8
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cand == '0) |=> (req_ready && !out_valid)); // R5
  AST_LP_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == DM_LOWEST) ##1 (out_valid && out_ready) |=> !busy); // R7
endmodule

// File: tb/irq_dest_dispatch_bench.sv
module irq_dest_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int NROW = 13;

  // row: dest[28:21] logical[20] mode[19:17] vector[16:9] trig[8] expect[7:0]
  localparam logic [28:0] TAB [NROW] = '{
    {8'hFF, 1'b0, 3'd0, 8'h40, 1'b0, 8'hBF},  // R1 broadcast
    {8'h13, 1'b0, 3'd0, 8'h41, 1'b1, 8'h08},  // R2 duplicate ID, first wins
    {8'h16, 1'b0, 3'd0, 8'h42, 1'b0, 8'h00},  // R5 only absent slot matches
    {8'h00, 1'b1, 3'd0, 8'h43, 1'b1, 8'h00},  // R3 logical zero
    {8'h01, 1'b1, 3'd0, 8'h44, 1'b0, 8'h05},  // R4 single bit
    {8'h41, 1'b1, 3'd0, 8'h45, 1'b1, 8'h05},  // R4 absent slot skipped
    {8'h28, 1'b1, 3'd0, 8'h46, 1'b0, 8'h28},  // R4 two bits
    {8'hFF, 1'b1, 3'd1, 8'h47, 1'b1, 8'h20},  // R7 tie 5 vs 7
    {8'hFF, 1'b0, 3'd1, 8'h48, 1'b0, 8'h20},  // R7 via broadcast
    {8'h0A, 1'b1, 3'd1, 8'h49, 1'b1, 8'h02},  // R7 tie 1 vs 3
    {8'h10, 1'b0, 3'd2, 8'h4A, 1'b0, 8'h00},  // R8 mode 2
    {8'h14, 1'b0, 3'd0, 8'h4B, 1'b1, 8'h10},  // R2 unique ID
    {8'hFF, 1'b0, 3'd7, 8'h4C, 1'b0, 8'h00}   // R8 mode 7
  };
  localparam string TAGS [NROW] = '{"R1", "R2", "R5", "R3", "R4", "R4", "R4",
                                   "R7", "R7", "R7", "R8", "R2", "R8"};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [7:0]   req_dest = '0;
  logic         req_logical = 1'b0;
  logic [2:0]   req_mode = '0;
  logic [7:0]   req_vector = '0;
  logic         req_trig = 1'b0;
  logic [N-1:0] tgt_present = 8'hBF;
  logic [63:0]  tgt_phys_id = {8'h17, 8'h16, 8'h13, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
  logic [63:0]  tgt_log_id  = {8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h05, 8'h02, 8'h01};
  logic [31:0]  tgt_prio    = {4'd2, 4'd0, 4'd2, 4'd9, 4'd3, 4'd7, 4'd3, 4'd5};
  logic         busy;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [N-1:0] out_tgt;
  logic [7:0]   out_vector;
  logic         out_trig;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dest_dispatch u_irq_dest_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_logical(req_logical), .req_mode(req_mode),
    .req_vector(req_vector), .req_trig(req_trig), .tgt_present(tgt_present),
    .tgt_phys_id(tgt_phys_id), .tgt_log_id(tgt_log_id), .tgt_prio(tgt_prio),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_tgt(out_tgt),
    .out_vector(out_vector), .out_trig(out_trig)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // offered at a falling edge, taken at the next rising edge
  task automatic send(input logic [7:0] d, input logic lg, input logic [2:0] m,
                      input logic [7:0] v, input logic t);
    req_dest = d; req_logical = lg; req_mode = m; req_vector = v; req_trig = t;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // walk the beats, expecting ascending order over exp
  task automatic drain(input logic [7:0] exp, input logic [7:0] v, input logic t,
                       input string tag);
    logic [7:0] rem;
    int beats;
    rem = exp;
    beats = 0;
    while (out_valid && beats < 10) begin
      check(out_tgt == (rem & (~rem + 8'd1)), tag, 32'(out_tgt), 32'(rem & (~rem + 8'd1)));
      check(out_vector == v && out_trig == t, tag, {out_vector, 7'd0, out_trig},
            {v, 7'd0, t});
      rem = rem & ~out_tgt;
      beats++;
      @(negedge clk);
    end
    check(rem == 8'h00, tag, 32'(rem), 32'h0);
    check(!out_valid && req_ready && !busy, tag, {out_valid, req_ready, busy}, 32'b010);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!out_valid && !busy && req_ready, "R11", {out_valid, busy, req_ready}, 32'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !busy && req_ready, "R11", {out_valid, busy, req_ready}, 32'b001);

    for (int r = 0; r < NROW; r++) begin
      send(TAB[r][28:21], TAB[r][20], TAB[r][19:17], TAB[r][16:9], TAB[r][8]);
      drain(TAB[r][7:0], TAB[r][16:9], TAB[r][8], TAGS[r]);
    end

    // R10 back-pressure, R9 request during dispatch is ignored
    out_ready = 1'b0;
    send(8'hFF, 1'b0, 3'd0, 8'h77, 1'b1);
    check(out_valid && out_tgt == 8'h01, "R10", 32'(out_tgt), 32'h01);
    req_dest = 8'h10; req_logical = 1'b0; req_mode = 3'd1; req_vector = 8'h99;
    req_trig = 1'b0; req_valid = 1'b1;
    check(busy && !req_ready, "R9", {busy, req_ready}, 32'b10);
    repeat (3) @(negedge clk);
    check(out_valid && out_tgt == 8'h01 && out_vector == 8'h77 && out_trig,
          "R10", {out_vector, out_tgt}, {8'h77, 8'h01});
    req_valid = 1'b0;
    out_ready = 1'b1;
    drain(8'hBF, 8'h77, 1'b1, "R9");
    @(negedge clk);
    check(!out_valid, "R9", 32'(out_valid), 32'h0);

    // R6 mid-stream stall keeps the order
    send(8'h28, 1'b1, 3'd0, 8'h12, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    check(out_tgt == 8'h20, "R6", 32'(out_tgt), 32'h20);
    @(negedge clk);
    out_ready = 1'b1;
    drain(8'h20, 8'h12, 1'b0, "R6");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule